// File: doc/BRIEF.md
# Banked 20-bit address extension unit

This unit widens the 16-bit address of an 8-bit CPU core into a 20-bit physical address, so the core can reach 1 MB as sixteen 64 KB banks. It holds two 4-bit bank registers. The execution bank supplies the upper four address bits for almost every bus cycle: opcode fetches, stack traffic, vector fetches, zero-page pointer reads and ordinary data accesses. The indirect bank supplies them only for the final operand access of an indirect-indexed load or store. The core marks that access with a dedicated input.

Both registers sit at CPU addresses 0 and 1 in every bank, with the execution bank at 0 and the indirect bank at 1. A CPU write there stores the low four bits. The write is still forwarded to memory, and the new bank applies from the next bus cycle. A CPU read there returns the register value, zero-extended, in place of memory data. All other reads pass memory data through unchanged.

There is no sequencing state. Each bus cycle is decoded on its own, and the only storage is the two bank registers.

Top module: `bank_addr_ext`

## Requirements
- R1: After reset both bank registers hold 4'hF, so reads of address 0 and 1 return 8'h0F and physical address bits 19:16 are 4'hF.
- R2: A valid write to address 0 stores write data bits 3:0 in the execution bank register.
- R3: A valid write to address 1 stores write data bits 3:0 in the indirect bank register.
- R4: With the indirect operand flag low, the physical address is {execution bank, CPU address}.
- R5: With the indirect operand flag high, the physical address is {indirect bank, CPU address}.
- R6: A read of address 0 or 1 returns {4'h0, register value} in place of memory data, and the upper four bits are always zero.
- R7: A read of any address of 2 or above returns the memory read data unchanged.
- R8: Register decode depends only on the 16-bit CPU address, whatever the bank values and the indirect flag are.
- R9: A bank write does not change the physical address of its own cycle. The new bank applies from the next cycle onward.
- R10: Every valid write, including writes to addresses 0 and 1, is forwarded to memory with its write enable and data.
- R11: A write while bus_valid is low changes neither bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus cycle active |
| bus_we | input | 1 | Bus cycle is a write |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| ind_operand | input | 1 | Current access is the operand of an indirect-indexed load/store |
| mem_rdata | input | 8 | Read data from memory |
| phys_addr | output | 20 | Physical address to memory |
| mem_we | output | 1 | Write enable to memory |
| mem_wdata | output | 8 | Write data to memory |
| bus_rdata | output | 8 | Read data to CPU |

## Verification
The hardest case to bring about is the cycle right after a write to address 0. The address of the write cycle itself must still carry the old bank, and the following cycle must carry the new one. The stimulus therefore issues a non-indirect read immediately after each bank write.

A second hard case is a register access made with the indirect flag high. There the address is formed from the indirect bank, but the read data must still come from the register. A vector reading address 1 with the flag raised covers it. A write with bus_valid low is followed by a register readback, which checks that nothing was stored.

// File: rtl/bankx_pkg.sv
package bankx_pkg;
    parameter int CPU_AW    = 16;
    parameter int BANK_W    = 4;
    parameter int DATA_W    = 8;
    parameter int REG_COUNT = 2;
    localparam int PHYS_AW  = CPU_AW + BANK_W;
    localparam int IDX_W    = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
    localparam int EXEC_IDX = 0;
    localparam int IND_IDX  = 1;
    typedef logic [BANK_W-1:0] bank_t;
    localparam bank_t RESET_BANK = '1;
endpackage

// File: rtl/bankx_regs.sv
module bankx_regs
    import bankx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              we,
    input  logic [CPU_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bank_t             exec_bank,
    output bank_t             ind_bank,
    output logic              reg_hit,
    output logic [IDX_W-1:0]  hit_idx
);
    bank_t bank_q [REG_COUNT];

    always_comb begin
        reg_hit = (addr < CPU_AW'(REG_COUNT));
        hit_idx = addr[IDX_W-1:0];
    end

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= RESET_BANK;
            else if (valid && we && reg_hit && hit_idx == IDX_W'(g))
                bank_q[g] <= wdata[BANK_W-1:0];
        end
    end

    assign exec_bank = bank_q[EXEC_IDX];
    assign ind_bank  = bank_q[IND_IDX];

    // R2
    wr_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && we && addr == CPU_AW'(EXEC_IDX)) |=> exec_bank == $past(wdata[BANK_W-1:0]));
    // R3
    wr_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && we && addr == CPU_AW'(IND_IDX)) |=> ind_bank == $past(wdata[BANK_W-1:0]));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && we && reg_hit) |=> ($stable(exec_bank) && $stable(ind_bank)));
endmodule

// File: rtl/bankx_addr.sv
module bankx_addr
    import bankx_pkg::*;
(
    input  bank_t              exec_bank,
    input  bank_t              ind_bank,
    input  logic               ind_operand,
    input  logic [CPU_AW-1:0]  addr,
    output logic [PHYS_AW-1:0] phys_addr
);
    bank_t sel_bank;

    always_comb begin
        sel_bank  = ind_operand ? ind_bank : exec_bank;
        phys_addr = {sel_bank, addr};
    end
endmodule

// File: rtl/bankx_rdmux.sv
module bankx_rdmux
    import bankx_pkg::*;
(
    input  logic              reg_hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  bank_t             exec_bank,
    input  bank_t             ind_bank,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rdata
);
    bank_t reg_val;

    always_comb begin
        reg_val = (hit_idx == IDX_W'(IND_IDX)) ? ind_bank : exec_bank;
        if (reg_hit)
            rdata = {{(DATA_W-BANK_W){1'b0}}, reg_val};
        else
            rdata = mem_rdata;
    end
endmodule

// File: rtl/bank_addr_ext.sv
module bank_addr_ext
    import bankx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_we,
    input  logic [CPU_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               ind_operand,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [DATA_W-1:0]  bus_rdata
);
    bank_t             exec_bank;
    bank_t             ind_bank;
    logic              reg_hit;
    logic [IDX_W-1:0]  hit_idx;

    bankx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (bus_valid),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .exec_bank (exec_bank),
        .ind_bank  (ind_bank),
        .reg_hit   (reg_hit),
        .hit_idx   (hit_idx)
    );

    bankx_addr u_addr (
        .exec_bank   (exec_bank),
        .ind_bank    (ind_bank),
        .ind_operand (ind_operand),
        .addr        (bus_addr),
        .phys_addr   (phys_addr)
    );

    bankx_rdmux u_rdmux (
        .reg_hit   (reg_hit),
        .hit_idx   (hit_idx),
        .exec_bank (exec_bank),
        .ind_bank  (ind_bank),
        .mem_rdata (mem_rdata),
        .rdata     (bus_rdata)
    );

    always_comb begin
        mem_we    = bus_valid && bus_we;
        mem_wdata = bus_wdata;
    end

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < CPU_AW'(REG_COUNT)) |-> bus_rdata[DATA_W-1:BANK_W] == '0);
    // R9
    next_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr == CPU_AW'(EXEC_IDX))
        |=> (ind_operand || phys_addr[PHYS_AW-1:CPU_AW] == $past(bus_wdata[BANK_W-1:0])));
    // R5
    ind_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_operand |-> phys_addr[PHYS_AW-1:CPU_AW] == ind_bank);
endmodule

// File: tb/bank_addr_ext_test.sv
module bank_addr_ext_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_we, ind_operand;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, mem_rdata;
    logic [19:0] phys_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata, bus_rdata;
    int          n_checks = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    bank_addr_ext uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ind_operand(ind_operand),
        .mem_rdata(mem_rdata), .phys_addr(phys_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .bus_rdata(bus_rdata)
    );

    // {addr16, we1, wdata8, ind1, mem_rdata8, exp_phys20, exp_rdata8, req4} = 66 bits
    localparam int NV = 10;
    localparam logic [65:0] VEC [NV] = '{
        {16'h0000, 1'b0, 8'h00, 1'b0, 8'hAA, 20'hF0000, 8'h0F, 4'd1},  // R1 R6 exec reg reset
        {16'h0001, 1'b0, 8'h00, 1'b0, 8'hAA, 20'hF0001, 8'h0F, 4'd1},  // R1 ind reg reset
        {16'h1234, 1'b0, 8'h00, 1'b0, 8'h5C, 20'hF1234, 8'h5C, 4'd7},  // R4 R7 pass-through
        {16'h0000, 1'b1, 8'hA3, 1'b0, 8'h00, 20'hF0000, 8'h00, 4'd9},  // R9 R10 old bank during write
        {16'h1234, 1'b0, 8'h00, 1'b0, 8'h66, 20'h31234, 8'h66, 4'd2},  // R2 R9 new bank next cycle
        {16'h0001, 1'b1, 8'h57, 1'b0, 8'h00, 20'h30001, 8'h00, 4'd3},  // R3 R8 R10 decode in bank 3
        {16'h8000, 1'b0, 8'h00, 1'b1, 8'h11, 20'h78000, 8'h11, 4'd5},  // R5 indirect operand
        {16'h8000, 1'b0, 8'h00, 1'b0, 8'h22, 20'h38000, 8'h22, 4'd4},  // R4 ordinary access
        {16'h0001, 1'b0, 8'h00, 1'b1, 8'hEE, 20'h70001, 8'h07, 4'd8},  // R8 R6 reg read with flag high
        {16'h0000, 1'b0, 8'h00, 1'b0, 8'hFF, 20'h30000, 8'h03, 4'd6}   // R6 upper bits zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [15:0] a,
                         input logic [7:0] d, input logic ind, input logic [7:0] m);
        @(negedge clk);
        bus_valid = v; bus_we = w; bus_addr = a; bus_wdata = d; ind_operand = ind; mem_rdata = m;
        #2;
    endtask

    initial begin
        #100000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_valid = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; ind_operand = 0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [65:0] v;
            v = VEC[i];
            drive(1'b1, v[49], v[65:50], v[48:41], v[40], v[39:32]);
            check($sformatf("R%0d vec%0d phys", v[3:0], i), 32'(phys_addr), 32'(v[31:12]));
            if (v[49]) begin
                check($sformatf("R10 vec%0d mem_we", i), 32'(mem_we), 32'd1);
                check($sformatf("R10 vec%0d mem_wdata", i), 32'(mem_wdata), 32'(v[48:41]));
            end else begin
                check($sformatf("R%0d vec%0d rdata", v[3:0], i), 32'(bus_rdata), 32'(v[11:4]));
            end
        end

        // R11: write with bus_valid low must not be stored
        drive(1'b0, 1'b1, 16'h0000, 8'h09, 1'b0, 8'h00);
        check("R11 no mem_we", 32'(mem_we), 32'd0);
        drive(1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h44);
        check("R11 exec bank kept", 32'(bus_rdata), 32'h03);

        // R2: high nibble of write data discarded
        drive(1'b1, 1'b1, 16'h0000, 8'hFC, 1'b1, 8'h00);
        check("R10 write with flag high forwarded", 32'(mem_we), 32'd1);
        drive(1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00);
        check("R2 low nibble only", 32'(bus_rdata), 32'h0C);
        check("R4 new exec bank", 32'(phys_addr), 32'hC0000);

        // R1: reset mid-run restores both banks
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        drive(1'b1, 1'b0, 16'h0001, 8'h00, 1'b1, 8'h00);
        check("R1 ind bank after reset", 32'(bus_rdata), 32'h0F);
        check("R1 phys after reset", 32'(phys_addr), 32'hF0001);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule